// File: doc/BRIEF.md
# Instruction Address Sequencer with Boot Vector Load

This block holds the address of the next instruction to fetch. When instructions run in sequence, it adds the byte length of the current instruction to that address. The decoder reports the length, and it can be one to five bytes. A taken branch replaces the address with a target. The target comes either from an immediate field or from a register operand, and a select input picks which one.

When reset is released, the sequencer does not start at a fixed address. It reads a two-byte boot vector through a byte-wide read port that has one cycle of latency. The byte at address 0 gives bits 7:0 of the start address and the byte at address 1 gives bits 15:8. The top four bits start at zero. Only after this load does the block raise its ready flag, which lets the fetch unit start issuing requests. From that point the block keeps the ready flag high until the next reset. All address arithmetic wraps modulo 2^20.

Top module: `pc_seq`

## Requirements
- R1: While `rst_n` is low, `fetch_ready` is 0 and `fetch_addr` is 0.
- R2: After reset is released, `vec_rd_en` is high with `vec_addr` = 0 before the first clock edge, and high with `vec_addr` = 1 after that edge. It is low from the second edge onward.
- R3: `vec_rdata` returns the byte for the address read on the previous cycle. On the third clock edge after reset release, `fetch_addr` is loaded with {4'h0, byte1, byte0} and `fetch_ready` goes to 1.
- R4: Once `fetch_ready` is 1, it stays 1 until reset is asserted.
- R5: While ready, with `br_valid` = 0 and `step_len` between 1 and 5, `fetch_addr` increases by `step_len` at the next edge.
- R6: While ready, with `br_valid` = 0 and `step_len` equal to 0, 6 or 7, `fetch_addr` does not change.
- R7: While ready, with `br_valid` = 1, `fetch_addr` takes the value of `br_imm` when `br_sel` = 0 and of `br_reg` when `br_sel` = 1.
- R8: When `br_valid` = 1 and `step_len` is a valid length in the same cycle, the branch target is loaded and the step is discarded.
- R9: Increments wrap modulo 2^20. For example, 0xFFFFE plus 5 gives 0x00003.
- R10: Before `fetch_ready` rises, `br_valid`, `br_sel`, `br_imm`, `br_reg` and `step_len` have no effect. The address loaded is the boot vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| step_len | input | 3 | Byte length of the current instruction; 0 means hold |
| br_valid | input | 1 | A branch is taken this cycle |
| br_sel | input | 1 | Target source: 0 selects the immediate, 1 selects the register |
| br_imm | input | 20 | Immediate branch target |
| br_reg | input | 20 | Register branch target |
| vec_rd_en | output | 1 | Read strobe for the boot vector memory |
| vec_addr | output | 20 | Byte address for the boot vector read |
| vec_rdata | input | 8 | Read data, valid one cycle after the strobe |
| fetch_addr | output | 20 | Address of the next instruction to fetch |
| fetch_ready | output | 1 | The address is valid and fetch may proceed |

## Verification
The assertions assume that the vector memory returns data exactly one cycle after each strobe. They also assume that the length and branch inputs are stable around the rising edge and are never X or Z. The bench memory model registers its data on the strobe, so the one-cycle latency holds. All stimulus is driven on the falling edge from the full legal value ranges, which includes the out-of-range lengths 6 and 7. The length is a 3-bit field, so no stimulus can go outside that field.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

  typedef enum logic [1:0] {
    ST_RD_LO = 2'd0,
    ST_RD_HI = 2'd1,
    ST_LOAD  = 2'd2,
    ST_RUN   = 2'd3
  } boot_state_e;

  typedef enum logic {
    TGT_IMM = 1'b0,
    TGT_REG = 1'b1
  } tgt_src_e;

endpackage

// File: rtl/pc_vec_loader.sv
module pc_vec_loader
  import pc_seq_pkg::*;
#(
  parameter int AW       = 20,
  parameter int DW       = 8,
  parameter int VEC_BASE = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] rdata,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          load_now,
  output logic [AW-1:0] boot_addr,
  output logic          running
);
  localparam int VW   = 2 * DW;
  localparam int PADW = AW - VW;
  localparam logic [AW-1:0] LO_ADDR = AW'(VEC_BASE);
  localparam logic [AW-1:0] HI_ADDR = AW'(VEC_BASE + 1);

  boot_state_e   state_q;
  logic [DW-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_RD_LO;
      lo_q    <= '0;
    end else begin
      unique case (state_q)
        ST_RD_LO: state_q <= ST_RD_HI;
        ST_RD_HI: begin
          lo_q    <= rdata;
          state_q <= ST_LOAD;
        end
        ST_LOAD:  state_q <= ST_RUN;
        default:  state_q <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    rd_en     = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
    rd_addr   = (state_q == ST_RD_HI) ? HI_ADDR : LO_ADDR;
    load_now  = (state_q == ST_LOAD);
    running   = (state_q == ST_RUN);
    boot_addr = {{PADW{1'b0}}, rdata, lo_q};
  end

endmodule

// File: rtl/pc_next_calc.sv
module pc_next_calc
  import pc_seq_pkg::*;
#(
  parameter int AW      = 20,
  parameter int LENW    = 3,
  parameter int MAX_LEN = 5
) (
  input  logic [AW-1:0]   cur_pc,
  input  logic            run,
  input  logic [LENW-1:0] len,
  input  logic            br_valid,
  input  logic            br_sel,
  input  logic [AW-1:0]   br_imm,
  input  logic [AW-1:0]   br_reg,
  output logic            take_branch,
  output logic            take_step,
  output logic [AW-1:0]   nxt_pc
);
  localparam int EXTW = AW + 1 - LENW;

  function automatic logic len_ok(input logic [LENW-1:0] l);
    return (l != '0) && (int'(l) <= MAX_LEN);
  endfunction

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] pc,
                                            input logic [LENW-1:0] l);
    logic [AW:0] sum;
    sum = {1'b0, pc} + {{EXTW{1'b0}}, l};
    return sum[AW-1:0];
  endfunction

  logic [AW-1:0] target;

  always_comb begin
    target      = (tgt_src_e'(br_sel) == TGT_REG) ? br_reg : br_imm;
    take_branch = run && br_valid;
    take_step   = run && !br_valid && len_ok(len);
    if (take_branch)    nxt_pc = target;
    else if (take_step) nxt_pc = advance(cur_pc, len);
    else                nxt_pc = cur_pc;
  end

endmodule

// File: rtl/pc_reg.sv
module pc_reg #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_boot,
  input  logic [AW-1:0] boot_addr,
  input  logic          upd_en,
  input  logic [AW-1:0] nxt_pc,
  output logic [AW-1:0] pc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)         pc_q <= '0;
    else if (load_boot) pc_q <= boot_addr;
    else if (upd_en)    pc_q <= nxt_pc;
  end
endmodule

// File: rtl/pc_seq.sv
module pc_seq #(
  parameter int AW       = 20,
  parameter int DW       = 8,
  parameter int LENW     = 3,
  parameter int MAX_LEN  = 5,
  parameter int VEC_BASE = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LENW-1:0] step_len,
  input  logic            br_valid,
  input  logic            br_sel,
  input  logic [AW-1:0]   br_imm,
  input  logic [AW-1:0]   br_reg,
  output logic            vec_rd_en,
  output logic [AW-1:0]   vec_addr,
  input  logic [DW-1:0]   vec_rdata,
  output logic [AW-1:0]   fetch_addr,
  output logic            fetch_ready
);
  logic          ev_vec_load;
  logic          ev_branch;
  logic          ev_step;
  logic          run;
  logic [AW-1:0] boot_addr;
  logic [AW-1:0] nxt_pc;

  pc_vec_loader #(.AW(AW), .DW(DW), .VEC_BASE(VEC_BASE)) u_loader (
    .clk       (clk),
    .rst_n     (rst_n),
    .rdata     (vec_rdata),
    .rd_en     (vec_rd_en),
    .rd_addr   (vec_addr),
    .load_now  (ev_vec_load),
    .boot_addr (boot_addr),
    .running   (run)
  );

  pc_next_calc #(.AW(AW), .LENW(LENW), .MAX_LEN(MAX_LEN)) u_calc (
    .cur_pc      (fetch_addr),
    .run         (run),
    .len         (step_len),
    .br_valid    (br_valid),
    .br_sel      (br_sel),
    .br_imm      (br_imm),
    .br_reg      (br_reg),
    .take_branch (ev_branch),
    .take_step   (ev_step),
    .nxt_pc      (nxt_pc)
  );

  pc_reg #(.AW(AW)) u_pc (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_boot (ev_vec_load),
    .boot_addr (boot_addr),
    .upd_en    (ev_branch || ev_step),
    .nxt_pc    (nxt_pc),
    .pc_q      (fetch_addr)
  );

  assign fetch_ready = run;

endmodule

// File: rtl/pc_seq_chk.sv
module pc_seq_chk #(
  parameter int AW      = 20,
  parameter int DW      = 8,
  parameter int LENW    = 3,
  parameter int MAX_LEN = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [LENW-1:0] step_len,
  input logic            br_valid,
  input logic            br_sel,
  input logic [AW-1:0]   br_imm,
  input logic [AW-1:0]   br_reg,
  input logic            vec_rd_en,
  input logic [AW-1:0]   vec_addr,
  input logic [AW-1:0]   fetch_addr,
  input logic            fetch_ready,
  input logic            ev_vec_load,
  input logic            ev_branch,
  input logic            ev_step
);
  logic len_bad;
  assign len_bad = (step_len == '0) || (int'(step_len) > MAX_LEN);

  AST_RD_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd_en && vec_addr == '0) |=> (vec_rd_en && vec_addr == AW'(1))); // R2
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready |-> !vec_rd_en); // R2
  AST_VEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vec_load |=> (fetch_ready && fetch_addr[AW-1:2*DW] == '0)); // R3
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready |=> fetch_ready); // R4
  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_step |=> (fetch_addr == AW'($past(fetch_addr) + AW'($past(step_len))))); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_ready && !br_valid && len_bad) |=> $stable(fetch_addr)); // R6
  AST_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_ready && br_valid) |=>
      (fetch_addr == ($past(br_sel) ? $past(br_reg) : $past(br_imm)))); // R7
  AST_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_ready && br_valid) |-> (ev_branch && !ev_step)); // R8
  AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_ready && !ev_vec_load) |=> $stable(fetch_addr)); // R10

endmodule

bind pc_seq pc_seq_chk #(.AW(AW), .DW(DW), .LENW(LENW), .MAX_LEN(MAX_LEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .step_len    (step_len),
  .br_valid    (br_valid),
  .br_sel      (br_sel),
  .br_imm      (br_imm),
  .br_reg      (br_reg),
  .vec_rd_en   (vec_rd_en),
  .vec_addr    (vec_addr),
  .fetch_addr  (fetch_addr),
  .fetch_ready (fetch_ready),
  .ev_vec_load (ev_vec_load),
  .ev_branch   (ev_branch),
  .ev_step     (ev_step)
);

// File: tb/pc_seq_tb.sv
`timescale 1ns/1ps
module pc_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  step_len = '0;
  logic        br_valid = 1'b0;
  logic        br_sel = 1'b0;
  logic [19:0] br_imm = '0;
  logic [19:0] br_reg = '0;
  logic        vec_rd_en;
  logic [19:0] vec_addr;
  logic [7:0]  vec_rdata = '0;
  logic [19:0] fetch_addr;
  logic        fetch_ready;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [7:0]  vec_lo = 8'h00;
  logic [7:0]  vec_hi = 8'h00;
  logic [19:0] exp_pc = '0;

  always #4 clk = ~clk;

  pc_seq u_dut (
    .clk(clk), .rst_n(rst_n), .step_len(step_len), .br_valid(br_valid),
    .br_sel(br_sel), .br_imm(br_imm), .br_reg(br_reg), .vec_rd_en(vec_rd_en),
    .vec_addr(vec_addr), .vec_rdata(vec_rdata), .fetch_addr(fetch_addr),
    .fetch_ready(fetch_ready)
  );

  // one-cycle latency byte memory holding the boot vector
  always @(posedge clk) begin
    if (vec_rd_en) begin
      if (vec_addr == 20'd0)      vec_rdata <= vec_lo;
      else if (vec_addr == 20'd1) vec_rdata <= vec_hi;
      else                        vec_rdata <= vec_addr[7:0] ^ 8'hA5;
    end
  end

  function automatic logic [19:0] model_next(logic [19:0] pc, logic bv, logic sel,
                                             logic [19:0] imm, logic [19:0] rg,
                                             logic [2:0] len);
    int unsigned s;
    if (bv) return sel ? rg : imm;
    if (len >= 3'd1 && len <= 3'd5) begin
      s = (int'(pc) + int'(len)) % (1 << 20);
      return 20'(s);
    end
    return pc;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(logic bv, logic sel, logic [19:0] imm, logic [19:0] rg,
                       logic [2:0] len, string req);
    @(negedge clk);
    br_valid = bv; br_sel = sel; br_imm = imm; br_reg = rg; step_len = len;
    exp_pc = model_next(exp_pc, bv, sel, imm, rg, len);
    @(posedge clk); #2;
    check(req, {12'h0, fetch_addr}, {12'h0, exp_pc});
    check("R4 ready held", {31'h0, fetch_ready}, 32'd1);
  endtask

  task automatic boot(logic [7:0] lo, logic [7:0] hi);
    @(negedge clk);
    rst_n = 1'b0;
    vec_lo = lo; vec_hi = hi;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", {31'h0, fetch_ready}, 32'd0);
    check("R1 addr in reset", {12'h0, fetch_addr}, 32'd0);
    rst_n = 1'b1;
    // R10: noise on inputs during the vector fetch
    br_valid = 1'b1; br_sel = 1'b0; br_imm = 20'h12345; step_len = 3'd3;
    #1;
    check("R2 first read en", {31'h0, vec_rd_en}, 32'd1);
    check("R2 first read addr", {12'h0, vec_addr}, 32'd0);
    @(posedge clk); #2;
    check("R2 second read en", {31'h0, vec_rd_en}, 32'd1);
    check("R2 second read addr", {12'h0, vec_addr}, 32'd1);
    check("R3 not ready yet", {31'h0, fetch_ready}, 32'd0);
    @(posedge clk); #2;
    check("R2 reads stop", {31'h0, vec_rd_en}, 32'd0);
    check("R10 addr unchanged", {12'h0, fetch_addr}, 32'd0);
    @(posedge clk); #2;
    check("R3 ready rises", {31'h0, fetch_ready}, 32'd1);
    check("R3 R10 vector loaded", {12'h0, fetch_addr}, {12'h0, 4'h0, hi, lo});
    exp_pc = {4'h0, hi, lo};
    @(negedge clk);
    br_valid = 1'b0; step_len = 3'd0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    boot(8'h34, 8'h12);

    // R5 every legal length
    for (int l = 1; l <= 5; l++) drive(1'b0, 1'b0, 20'h0, 20'h0, 3'(l), "R5 step");
    // R6 lengths that hold
    drive(1'b0, 1'b0, 20'h0, 20'h0, 3'd0, "R6 hold len0");
    drive(1'b0, 1'b0, 20'h0, 20'h0, 3'd6, "R6 hold len6");
    drive(1'b0, 1'b0, 20'h0, 20'h0, 3'd7, "R6 hold len7");
    // R7 both sources
    drive(1'b1, 1'b0, 20'hABCDE, 20'h11111, 3'd0, "R7 imm target");
    drive(1'b1, 1'b1, 20'hABCDE, 20'h54321, 3'd0, "R7 reg target");
    // R8 branch with a valid step in the same cycle
    drive(1'b1, 1'b0, 20'h00100, 20'h0, 3'd4, "R8 branch beats step");
    // R9 wrap
    drive(1'b1, 1'b1, 20'h0, 20'hFFFFE, 3'd0, "R9 set near top");
    drive(1'b0, 1'b0, 20'h0, 20'h0, 3'd5, "R9 wrap to 3");
    check("R9 wrapped value", {12'h0, fetch_addr}, 32'h3);

    // random traffic
    for (int i = 0; i < 1500; i++) begin
      logic bv;
      bv = ($urandom % 4) == 0;
      drive(bv, 1'($urandom), 20'($urandom), 20'($urandom), 3'($urandom),
            bv ? "R7 R8 random branch" : "R5 R6 R9 random step");
    end

    // second boot, all-ones vector, mid-run reset
    boot(8'hFF, 8'hFF);
    for (int l = 1; l <= 5; l++) drive(1'b0, 1'b0, 20'h0, 20'h0, 3'(l), "R5 after reboot");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule